// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip request/response port to an external asynchronous 128K x 8 static RAM. It accepts one request at a time through a valid/ready handshake. Each request carries a 17-bit address, 8 bits of write data and a write flag. The controller then runs a timed access on the memory pins: an address bus, an 8-bit data path with a drive enable, one low-active and one high-active chip select, and low-active read-enable and write strobes. When the access is finished, a one-cycle done pulse signals completion, and for reads the captured byte is returned with it.

The memory has no clock, so every timing rule is met by counting cycles of the system clock. Each timing is a nanosecond parameter. It is converted to a cycle count by ceiling division by the clock period, with a minimum of one cycle. While no access is running, the chip is deselected and rests in standby. During a write the read-enable stays HIGH for the whole cycle, so the memory never drives the bus while the controller drives it.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_ce` and `mem_dq_oe` are 0.
- R2: While `req_ready` is 1 the memory is in standby: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1.
- R3: `req_ready` falls at the edge that accepts a request and stays 0 until the access completes. A `req_valid` seen while `req_ready` is 0 is ignored: it does not change the address on the pins and does not write memory.
- R4: From acceptance until completion, `mem_addr` and `mem_dq_out` hold the accepted address and write data without change while the chip is selected.
- R5: A write selects the chip for SETUP cycles with `mem_we_n` HIGH. It then holds `mem_we_n` LOW for PULSE cycles, then keeps the chip selected with `mem_we_n` HIGH for RECOV cycles. `mem_oe_n` is 1 throughout.
- R6: `mem_dq_oe` is 1 only while `mem_we_n` is 0, and never while the memory is driving for a read.
- R7: A read selects the chip for SETUP cycles with both strobes HIGH. It then holds `mem_oe_n` LOW for ACCESS cycles and samples `mem_dq_in` on the last of them. The sampled byte appears on `rsp_rdata` together with `rsp_done`.
- R8: `rsp_done` is a one-cycle pulse in the first idle cycle after an access. Counted in clock edges from the accepting edge, it is due SETUP+PULSE+RECOV edges later for a write and SETUP+ACCESS+TURN edges later for a read.
- R9: When a read strobe ends, the chip is deselected at once and the controller waits TURN cycles, with drivers off, before it returns to idle.
- R10: Cycle counts are ceil(ns/period), with a minimum of 1. SETUP comes from the address setup time and ACCESS from the read access time. TURN comes from the bus release time. PULSE is the larger of the write pulse count and (address-to-end-of-write count minus SETUP). RECOV is the larger of the recovery count and (write cycle count minus SETUP minus PULSE). With the defaults (10 ns clock; 0/25/25/35/0/35/10 ns) the values are SETUP=1, PULSE=3, RECOV=1, ACCESS=4, TURN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done after a read |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
With default parameters, a write's done pulse is due 5 clock edges after the accepting edge and a read's is due 6. The write strobe lasts 3 cycles, the read strobe lasts 4, and the deselect follows in the very next cycle after a read strobe. The driver records the accepting edge number together with the expected latency and data in a queue. The monitor samples on falling clock edges, so each registered output is read half a cycle after the edge that set it, and every done pulse is compared against the head of that queue. Strobe widths, setup ordering and pin stability are measured cycle by cycle from the pins against counts the bench derives itself from the nanosecond figures.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, floored at one cycle
    function automatic int unsigned sub_min1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_reg.sv
module sram_strobe_reg
    import sram_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e nxt_phase,
    input  logic   nxt_write,
    output logic   ce_n,
    output logic   ce,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_oe
);
    typedef struct packed {
        logic ce_n;
        logic ce;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pins_t;

    pins_t d, q;

    always_comb begin
        logic sel;
        logic strobe;
        sel     = (nxt_phase == PH_SETUP) || (nxt_phase == PH_STROBE) || (nxt_phase == PH_HOLD);
        strobe  = (nxt_phase == PH_STROBE);
        d.ce_n  = !sel;
        d.ce    = sel;
        d.we_n  = !(strobe && nxt_write);
        d.oe_n  = !(strobe && !nxt_write);
        d.dq_oe = strobe && nxt_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        else
            q <= d;
    end

    assign ce_n  = q.ce_n;
    assign ce    = q.ce;
    assign oe_n  = q.oe_n;
    assign we_n  = q.we_n;
    assign dq_oe = q.dq_oe;

    // R6: drivers only inside the write strobe
    a_r6_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n);

    // R5: read enable held high whenever the write strobe is low
    a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R9: end of read strobe deselects the chip at the same edge
    a_r9_deselect_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (ce_n && !ce));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS      = 10,
    parameter int unsigned ADDR_W             = 17,
    parameter int unsigned DATA_W             = 8,
    parameter int unsigned T_ADDR_SETUP_NS    = 0,
    parameter int unsigned T_WE_PULSE_NS      = 25,
    parameter int unsigned T_ADDR_TO_WEND_NS  = 25,
    parameter int unsigned T_WRITE_CYCLE_NS   = 35,
    parameter int unsigned T_WRITE_RECOV_NS   = 0,
    parameter int unsigned T_READ_ACCESS_NS   = 35,
    parameter int unsigned T_BUS_RELEASE_NS   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    // R10: nanosecond figures turned into cycle counts
    localparam int unsigned SETUP_CYC  = ns_to_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC  = max2(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                              sub_min1(ns_to_cycles(T_ADDR_TO_WEND_NS, CLK_PERIOD_NS), SETUP_CYC));
    localparam int unsigned RECOV_CYC  = max2(ns_to_cycles(T_WRITE_RECOV_NS, CLK_PERIOD_NS),
                                              sub_min1(ns_to_cycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS),
                                                       SETUP_CYC + PULSE_CYC));
    localparam int unsigned ACCESS_CYC = ns_to_cycles(T_READ_ACCESS_NS, CLK_PERIOD_NS);
    localparam int unsigned TURN_CYC   = ns_to_cycles(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC    = max2(max2(max2(SETUP_CYC, PULSE_CYC), max2(RECOV_CYC, ACCESS_CYC)),
                                              TURN_CYC);
    localparam int CNT_W = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        phase_e            phase;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ready;
        logic              done;
    } ctrl_t;

    ctrl_t            d, q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid && q.ready) begin
                    d.phase  = PH_SETUP;
                    d.ready  = 1'b0;
                    d.write  = req_write;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    d.phase  = PH_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = q.write ? LD_PULSE : LD_ACCESS;
                end
            end
            PH_STROBE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (q.write) begin
                        d.phase = PH_HOLD;
                        tmr_val = LD_RECOV;
                    end else begin
                        d.phase = PH_RECOVER;
                        d.rdata = mem_dq_in;
                        tmr_val = LD_TURN;
                    end
                end
            end
            PH_HOLD, PH_RECOVER: begin
                if (tmr_expired) begin
                    d.phase = PH_IDLE;
                    d.ready = 1'b1;
                    d.done  = 1'b1;
                end
            end
            default: begin
                d.phase = PH_IDLE;
                d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.write <= 1'b0;
            q.addr  <= '0;
            q.wdata <= '0;
            q.rdata <= '0;
            q.ready <= 1'b1;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_strobe_reg strobe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_phase (d.phase),
        .nxt_write (d.write),
        .ce_n      (mem_ce_n),
        .ce        (mem_ce),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    assign req_ready  = q.ready;
    assign rsp_done   = q.done;
    assign rsp_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_dq_out = q.wdata;

    // R2: idle means standby
    a_r2_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n));

    // R4: pins stable while selected
    a_r4_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R8: done lasts one cycle and arrives with the return to idle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R3: accepting a request drops ready on the next edge
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

    localparam int PER = 10;

    function automatic int ceil1(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R10: expected counts from the default nanosecond figures
    localparam int BS = ceil1(0);
    localparam int BW = mx(ceil1(25), mx(ceil1(25) - BS, 1));
    localparam int BH = mx(ceil1(0), mx(ceil1(35) - BS - BW, 1));
    localparam int BA = ceil1(35);
    localparam int BT = ceil1(10);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n;

    always #5 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem [0:131071];
    logic [7:0] wlat;
    logic       sel_w, wr_act, rd_act;

    function automatic logic [7:0] init_val(input int a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    initial for (int i = 0; i < 131072; i++) mem[i] = init_val(i);

    assign sel_w     = !mem_ce_n && mem_ce;
    assign wr_act    = sel_w && !mem_we_n;
    assign rd_act    = sel_w && mem_we_n && !mem_oe_n;
    assign mem_dq_in = rd_act ? mem[mem_addr] : 8'h00;

    always @(*) if (wr_act && mem_dq_oe) wlat = mem_dq_out;
    always @(negedge wr_act) if (rst_n) mem[mem_addr] = wlat;

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         wr;
        int         addr;
        logic [7:0] data;
        int         lat;
        int         acc;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] shadow [int];
    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] expect_rd(input int a);
        return shadow.exists(a) ? shadow[a] : init_val(a);
    endfunction

    task automatic do_req(input bit w, input int a, input logic [7:0] dat);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a[16:0];
        req_wdata = dat;
        it.wr   = w;
        it.addr = a;
        it.acc  = cyc + 1;
        it.lat  = w ? (BS + BW + BH) : (BS + BA + BT);
        it.data = w ? dat : expect_rd(a);
        if (w) shadow[a] = dat;
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk((cyc - it.acc) == it.lat, "R8", "done latency", cyc - it.acc, it.lat);
                if (!it.wr)
                    chk(rsp_rdata == it.data, "R7", "read data", rsp_rdata, it.data);
            end
        end
    end

    // ---------------- pin protocol monitor ----------------
    int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0;
    int we_cnt = 0, oe_cnt = 0;
    logic prev_sel = 1'b0, prev_we_n = 1'b1, prev_oe_n = 1'b1;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && (mem_we_n || rd_act)) v_r6++;
            if (!mem_we_n && !mem_oe_n) v_r5++;
            if (mem_dq_oe == 1'b0 && !mem_we_n) v_r6++;
            if (req_ready && !(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n)) v_r2++;
            if (req_ready && sel_w) v_r3++;
            if (sel_w && prev_sel && (mem_addr != prev_addr || mem_dq_out != prev_dq)) v_r4++;
            if (!mem_we_n && prev_we_n)
                chk(prev_sel, "R5", "chip selected before strobe", prev_sel, 1);
            if (!mem_we_n) we_cnt++;
            else if (we_cnt != 0) begin
                chk(we_cnt == BW, "R5", "write strobe width", we_cnt, BW);
                chk(sel_w, "R5", "recovery keeps chip selected", sel_w, 1);
                we_cnt = 0;
            end
            if (!mem_oe_n) oe_cnt++;
            else if (oe_cnt != 0) begin
                chk(oe_cnt == BA, "R7", "read strobe width", oe_cnt, BA);
                oe_cnt = 0;
            end
            if (mem_oe_n && !prev_oe_n) begin
                chk(mem_ce_n && !mem_ce && !mem_dq_oe, "R9", "deselect after read",
                    {mem_ce_n, mem_ce, mem_dq_oe}, 3'b100);
                chk(!req_ready, "R9", "turnaround before idle", req_ready, 0);
            end
            prev_sel  = sel_w;
            prev_we_n = mem_we_n;
            prev_oe_n = mem_oe_n;
            prev_addr = mem_addr;
            prev_dq   = mem_dq_out;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * PER);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(rsp_done == 1'b0, "R1", "done", rsp_done, 0);
        chk({mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe} == 5'b10110, "R1", "pins",
            {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && !mem_ce, "R2", "standby after reset", {mem_ce_n, mem_ce}, 2'b10);
        chk(BS == 1 && BW == 3 && BH == 1 && BA == 4 && BT == 1, "R10", "derived counts",
            BS * 10000 + BW * 1000 + BH * 100 + BA * 10 + BT, 13141);

        // reads of untouched locations, then writes at the address extremes
        do_req(0, 17'h00000, 8'h00);
        do_req(0, 17'h1FFFF, 8'h00);
        do_req(1, 17'h00000, 8'hA5);
        do_req(1, 17'h1FFFF, 8'h3C);
        do_req(1, 17'h0AAAA, 8'hFF);
        do_req(1, 17'h15555, 8'h00);
        // back-to-back read after write at the same address
        do_req(0, 17'h00000, 8'h00);
        do_req(0, 17'h1FFFF, 8'h00);
        do_req(0, 17'h0AAAA, 8'h00);
        do_req(0, 17'h15555, 8'h00);
        // overwrite, then write directly after a read (turnaround)
        do_req(1, 17'h00000, 8'h5A);
        do_req(0, 17'h00000, 8'h00);
        do_req(1, 17'h00001, 8'h81);
        do_req(0, 17'h00001, 8'h00);

        // R3: request offered while busy is ignored
        do_req(1, 17'h00100, 8'h11);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 17'h00200;
        req_wdata = 8'hEE;
        @(negedge clk);
        chk(req_ready == 1'b0, "R3", "ready low while busy", req_ready, 0);
        chk(mem_addr == 17'h00100, "R3", "address unaffected", mem_addr, 17'h00100);
        @(negedge clk);
        req_valid = 1'b0;
        do_req(0, 17'h00200, 8'h00);
        do_req(0, 17'h00100, 8'h00);

        for (int k = 0; k < 8; k++) do_req(1, 17'h01000 + k * 17'h2345, 8'(k * 37 + 1));
        for (int k = 0; k < 8; k++) do_req(0, 17'h01000 + k * 17'h2345, 8'h00);

        repeat (BS + BA + BT + 4) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "all responses returned", exp_q.size(), 0);
        chk(v_r2 == 0, "R2", "standby violations", v_r2, 0);
        chk(v_r3 == 0, "R3", "selected while ready", v_r3, 0);
        chk(v_r4 == 0, "R4", "pin changes while selected", v_r4, 0);
        chk(v_r5 == 0, "R5", "read enable low during write", v_r5, 0);
        chk(v_r6 == 0, "R6", "driver enable violations", v_r6, 0);
        summary();
    end

endmodule